// File: doc/BRIEF.md
# Debug Command Sequencer

This block decodes the byte stream that a debug host shifts in and turns it into actions for a CPU. Every operation begins with one command byte. The command decides how many operand bytes must follow. The block waits for all of them, with no time limit between bytes, and acts only when the last one arrives. Two commands, single-step and return-to-background, are carried out by the block itself as one-cycle pulses. All other known commands are handed to service code in a utility ROM. For these, the block publishes the command code, turns the ROM on and requests a jump to a fixed vector. It then reports busy on a two-bit status field.

While the ROM works, two flags control the flow of bytes. A transmit-complete flag is raised by the ROM when it has loaded a byte for the host, and the block lowers it when a shift cycle finishes. A done flag is raised by the ROM at the end of its task. The block acknowledges it by lowering the flag and going back to idle. An unknown byte does nothing.

Byte collection cannot recover from a broken stream on its own. The only way out is a synchronous disable input, which discards all progress. The block restarts in idle once the disable is released.

Top module: `dbg_cmd_seq`

## Requirements
- R1: After reset the status is 01 (idle), the command field is 0, the ROM enable, both flags and all pulses are low, and the status is never 11.
- R2: A command byte has bits [7:4] equal to zero and a code in bits [3:0]. The codes are: 1 read register map, 2 read stack, 3 read register, 4 write register, 5 read data memory, 6 write data memory, 7 unlock, 8 single-step, 9 return. Any other byte received in idle is a no-operation: the status stays 01, no pulse or jump occurs and the command field keeps its value.
- R3: The follow-on byte counts are 0, 0, 1, 3, 2, 4 and 0 for codes 1 to 7. The status stays 01 and no jump occurs until the last follow-on byte arrives, however many idle cycles separate the bytes.
- R4: One cycle after the byte that completes a ROM command (the command byte itself when the count is 0), the command field holds the code, the ROM enable is 1 and stays 1, the status is 10 and the jump output is high for exactly one cycle with the address 0x8010.
- R5: Follow-on byte k (counting from 0) appears in args_o bits [8k+7:8k]. All argument bytes are cleared when a ROM command byte is accepted.
- R6: Code 8 gives a one-cycle step pulse and code 9 a one-cycle return pulse, each in the cycle after the command byte. The status stays 01, and the command field and ROM enable are unchanged.
- R7: A ROM transmit-set sets the transmit-complete flag one cycle later. A byte-done strobe clears it one cycle later. If both arrive in the same cycle, the set wins.
- R8: While busy, a ROM done-set raises the done flag one cycle later. One cycle after that, the flag is 0 and the status is 01. A done-set outside busy is ignored. Bytes received while busy are not decoded as commands.
- R9: While the disable input is high, the status is 00, the command field, both flags and any partial collection are cleared, incoming bytes are ignored, and the ROM enable keeps its value. One cycle after the disable is released, the status is 01 and a new command starts from its first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dis_i | input | 1 | Synchronous disable; clears collection and flags |
| rx_byte_i | input | 8 | Byte delivered by the host shifter |
| rx_done_i | input | 1 | One-cycle strobe marking a completed byte shift |
| rom_txc_set_i | input | 1 | ROM sets the transmit-complete flag |
| rom_rod_set_i | input | 1 | ROM sets the task-done flag |
| status_o | output | 2 | 00 off, 01 idle, 10 busy |
| cmd_o | output | 4 | Code of the last launched ROM command |
| args_o | output | 32 | Collected follow-on bytes, first byte in bits [7:0] |
| rom_en_o | output | 1 | Utility ROM enable |
| jump_o | output | 1 | One-cycle jump request |
| jump_addr_o | output | 16 | Jump target vector |
| step_o | output | 1 | One-cycle single-step pulse |
| ret_o | output | 1 | One-cycle return-to-background pulse |
| txc_o | output | 1 | Transmit-complete flag |
| rod_o | output | 1 | ROM task-done flag |

## Verification
Each ROM command is sent with its own number of operand bytes, and each intermediate byte is checked for the absence of a launch. This catches a wrong count, for example a launch after two bytes where three are needed. The write-memory stream puts long idle gaps between its four bytes and uses distinct values, which exposes both a hidden timeout and any swap in byte order. A one-byte read that follows it shows whether stale upper bytes are cleared. Several other patterns test what the block must leave alone: a command byte sent while busy, bytes with a nonzero upper nibble, a byte sent while disabled, and a disable partway through a collection followed by a fresh command.

// File: rtl/dbg_cmd_pkg.sv
package dbg_cmd_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'b00,
    ST_IDLE = 2'b01,
    ST_BUSY = 2'b10,
    ST_COLL = 2'b11
  } st_e;

  localparam logic [3:0] C_RD_MAP = 4'd1;
  localparam logic [3:0] C_RD_STK = 4'd2;
  localparam logic [3:0] C_RD_REG = 4'd3;
  localparam logic [3:0] C_WR_REG = 4'd4;
  localparam logic [3:0] C_RD_MEM = 4'd5;
  localparam logic [3:0] C_WR_MEM = 4'd6;
  localparam logic [3:0] C_UNLOCK = 4'd7;
  localparam logic [3:0] C_STEP   = 4'd8;
  localparam logic [3:0] C_RET    = 4'd9;

  function automatic logic [3:0] fol_cnt(input logic [3:0] c);
    case (c)
      C_RD_REG: fol_cnt = 4'd1;
      C_WR_REG: fol_cnt = 4'd3;
      C_RD_MEM: fol_cnt = 4'd2;
      C_WR_MEM: fol_cnt = 4'd4;
      default:  fol_cnt = 4'd0;
    endcase
  endfunction

  function automatic logic is_rom(input logic [3:0] c);
    is_rom = (c >= C_RD_MAP) && (c <= C_UNLOCK);
  endfunction
endpackage

// File: rtl/dbg_arg_collect.sv
module dbg_arg_collect #(
  parameter int DW       = 8,
  parameter int MAX_ARGS = 4,
  localparam int CW      = $clog2(MAX_ARGS + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_i,
  input  logic                   load_i,
  input  logic [DW-1:0]          byte_i,
  output logic [CW-1:0]          cnt_o,
  output logic [MAX_ARGS*DW-1:0] args_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (load_i) cnt_q <= cnt_q + 1'b1;
  end

  for (genvar g = 0; g < MAX_ARGS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               args_o[g*DW +: DW] <= '0;
      else if (clr_i)                            args_o[g*DW +: DW] <= '0;
      else if (load_i && cnt_q == CW'(g))        args_o[g*DW +: DW] <= byte_i;
    end
  end

  assign cnt_o = cnt_q;

  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(MAX_ARGS));
  p_clr_empty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0 && args_o == '0));
endmodule

// File: rtl/dbg_rom_hs.sv
module dbg_rom_hs (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic busy_i,
  input  logic shift_done_i,
  input  logic txc_set_i,
  input  logic rod_set_i,
  input  logic ack_i,
  output logic txc_o,
  output logic rod_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           txc_o <= 1'b0;
    else if (clr_i)        txc_o <= 1'b0;
    else if (txc_set_i)    txc_o <= 1'b1;
    else if (shift_done_i) txc_o <= 1'b0;
  end

  // acknowledge beats a fresh set; done only counts while busy
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    rod_o <= 1'b0;
    else if (clr_i || ack_i)        rod_o <= 1'b0;
    else if (rod_set_i && busy_i)   rod_o <= 1'b1;
  end

  p_txc_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_done_i && !txc_set_i && !clr_i) |=> !txc_o);
  p_txc_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txc_set_i && !clr_i) |=> txc_o);
  p_rod_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !rod_o) |=> !rod_o);
endmodule

// File: rtl/dbg_cmd_seq.sv
module dbg_cmd_seq
  import dbg_cmd_pkg::*;
#(
  parameter int              DW       = 8,
  parameter int              MAX_ARGS = 4,
  parameter int              AW       = 16,
  parameter logic [AW-1:0]   JUMP_VEC = 16'h8010,
  localparam int             CW       = $clog2(MAX_ARGS + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   dis_i,
  input  logic [DW-1:0]          rx_byte_i,
  input  logic                   rx_done_i,
  input  logic                   rom_txc_set_i,
  input  logic                   rom_rod_set_i,
  output logic [1:0]             status_o,
  output logic [3:0]             cmd_o,
  output logic [MAX_ARGS*DW-1:0] args_o,
  output logic                   rom_en_o,
  output logic                   jump_o,
  output logic [AW-1:0]          jump_addr_o,
  output logic                   step_o,
  output logic                   ret_o,
  output logic                   txc_o,
  output logic                   rod_o
);
  st_e           st_q, st_d;
  logic [3:0]    code, pend_q;
  logic [CW-1:0] cnt, need_q;
  logic          known, accept, acc_rom, acc_zero;
  logic          coll_ld, coll_last, launch, done_ack;

  assign code     = rx_byte_i[3:0];
  assign known    = (rx_byte_i[DW-1:4] == '0) && (code >= C_RD_MAP) && (code <= C_RET);
  assign accept   = (st_q == ST_IDLE) && rx_done_i && !dis_i;
  assign acc_rom  = accept && known && is_rom(code);
  assign acc_zero = acc_rom && (fol_cnt(code) == 4'd0);
  assign coll_ld  = (st_q == ST_COLL) && rx_done_i && !dis_i;
  assign coll_last = coll_ld && (cnt == need_q - 1'b1);
  assign launch   = acc_zero || coll_last;
  assign done_ack = (st_q == ST_BUSY) && rod_o && !dis_i;

  always_comb begin
    st_d = st_q;
    if (dis_i) st_d = ST_OFF;
    else begin
      case (st_q)
        ST_OFF:  st_d = ST_IDLE;
        ST_IDLE: if (acc_rom) st_d = acc_zero ? ST_BUSY : ST_COLL;
        ST_COLL: if (coll_last) st_d = ST_BUSY;
        ST_BUSY: if (done_ack) st_d = ST_IDLE;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      pend_q   <= '0;
      need_q   <= '0;
      cmd_o    <= '0;
      rom_en_o <= 1'b0;
      jump_o   <= 1'b0;
      step_o   <= 1'b0;
      ret_o    <= 1'b0;
    end else begin
      st_q   <= st_d;
      jump_o <= launch;
      step_o <= accept && known && (code == C_STEP);
      ret_o  <= accept && known && (code == C_RET);
      if (acc_rom) begin
        pend_q <= code;
        need_q <= CW'(fol_cnt(code));
      end
      if (dis_i)       cmd_o <= '0;
      else if (launch) cmd_o <= acc_zero ? code : pend_q;
      if (launch) rom_en_o <= 1'b1;
    end
  end

  assign status_o    = (st_q == ST_COLL) ? 2'b01 : st_q;
  assign jump_addr_o = JUMP_VEC;

  dbg_arg_collect #(.DW(DW), .MAX_ARGS(MAX_ARGS)) u_args (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (dis_i || acc_rom),
    .load_i (coll_ld),
    .byte_i (rx_byte_i),
    .cnt_o  (cnt),
    .args_o (args_o)
  );

  dbg_rom_hs u_hs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (dis_i),
    .busy_i       (st_q == ST_BUSY),
    .shift_done_i (rx_done_i),
    .txc_set_i    (rom_txc_set_i),
    .rod_set_i    (rom_rod_set_i),
    .ack_i        (done_ack),
    .txc_o        (txc_o),
    .rod_o        (rod_o)
  );

  p_status_legal_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o != 2'b11);
  p_jump_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jump_o |=> !jump_o);
  p_jump_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jump_o |-> (status_o == 2'b10 && rom_en_o));
  p_coll_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_COLL && !coll_last) |=> !jump_o);
  p_direct_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o || ret_o) |-> (status_o == 2'b01 && !(step_o && ret_o)));
  p_done_ack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_ack |=> (status_o == 2'b01 && !rod_o));
  p_dis_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_i |=> (status_o == 2'b00 && cmd_o == '0 && !txc_o && !rod_o));
endmodule

// File: tb/sim_dbg_cmd_seq.sv
`timescale 1ns/1ps
module sim_dbg_cmd_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dis = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rx_done = 1'b0;
  logic        txc_set = 1'b0;
  logic        rod_set = 1'b0;
  logic [1:0]  status;
  logic [3:0]  cmd;
  logic [31:0] args;
  logic        rom_en, jump, step, ret, txc, rod;
  logic [15:0] jaddr;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  dbg_cmd_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .dis_i(dis), .rx_byte_i(rx_byte),
    .rx_done_i(rx_done), .rom_txc_set_i(txc_set), .rom_rod_set_i(rod_set),
    .status_o(status), .cmd_o(cmd), .args_o(args), .rom_en_o(rom_en),
    .jump_o(jump), .jump_addr_o(jaddr), .step_o(step), .ret_o(ret),
    .txc_o(txc), .rod_o(rod)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); rx_byte = b; rx_done = 1'b1;
    @(negedge clk); rx_done = 1'b0;
  endtask

  task automatic finish_busy();
    @(negedge clk); rod_set = 1'b1;
    @(negedge clk); rod_set = 1'b0;
    chk("R8 rod raised", {31'd0, rod}, 1);
    chk("R8 still busy", {30'd0, status}, 2'b10);
    @(negedge clk);
    chk("R8 rod acked", {31'd0, rod}, 0);
    chk("R8 back idle", {30'd0, status}, 2'b01);
  endtask

  task automatic t_reset();
    chk("R1 status", {30'd0, status}, 2'b01);
    chk("R1 cmd", {28'd0, cmd}, 0);
    chk("R1 outs", {26'd0, rom_en, jump, step, ret, txc, rod}, 0);
  endtask

  task automatic t_nop();
    logic [7:0] nops[3] = '{8'h0B, 8'h00, 8'h1F};
    foreach (nops[i]) begin
      send(nops[i]);
      chk("R2 nop status", {30'd0, status}, 2'b01);
      chk("R2 nop pulses", {29'd0, jump, step, ret}, 0);
      chk("R2 nop cmd", {28'd0, cmd}, 0);
    end
  endtask

  task automatic t_rd_map();
    send(8'h01);
    chk("R4 busy", {30'd0, status}, 2'b10);
    chk("R4 cmd", {28'd0, cmd}, 1);
    chk("R4 rom_en/jump", {30'd0, rom_en, jump}, 2'b11);
    chk("R4 vector", {16'd0, jaddr}, 32'h8010);
    @(negedge clk);
    chk("R4 jump one cycle", {31'd0, jump}, 0);
    chk("R4 rom_en held", {31'd0, rom_en}, 1);
    @(negedge clk); txc_set = 1'b1;
    @(negedge clk); txc_set = 1'b0;
    chk("R7 txc set", {31'd0, txc}, 1);
    send(8'h08);
    chk("R7 txc cleared by shift", {31'd0, txc}, 0);
    chk("R8 busy byte not decoded", {29'd0, step, status}, 3'b010);
    @(negedge clk); txc_set = 1'b1; rx_byte = 8'h09; rx_done = 1'b1;
    @(negedge clk); txc_set = 1'b0; rx_done = 1'b0;
    chk("R7 set wins", {31'd0, txc}, 1);
    chk("R8 busy ret ignored", {31'd0, ret}, 0);
    finish_busy();
  endtask

  task automatic t_rod_idle();
    @(negedge clk); rod_set = 1'b1;
    @(negedge clk); rod_set = 1'b0;
    chk("R8 rod ignored in idle", {31'd0, rod}, 0);
    chk("R8 idle kept", {30'd0, status}, 2'b01);
  endtask

  task automatic t_wr_mem();
    logic [7:0] d[4] = '{8'h11, 8'h22, 8'h33, 8'h44};
    send(8'h06);
    chk("R3 collecting", {30'd0, status}, 2'b01);
    for (int i = 0; i < 4; i++) begin
      if (i == 1) repeat (20) @(negedge clk);
      send(d[i]);
      if (i < 3) begin
        chk("R3 no early launch", {30'd0, status, jump}, 3'b010);
      end
    end
    chk("R3 launch after 4", {30'd0, status}, 2'b10);
    chk("R4 jump wr_mem", {31'd0, jump}, 1);
    chk("R4 cmd wr_mem", {28'd0, cmd}, 6);
    chk("R5 byte order", args, 32'h44332211);
    finish_busy();
  endtask

  task automatic t_rd_reg();
    send(8'h03);
    send(8'hA5);
    chk("R5 stale cleared", args, 32'h000000A5);
    chk("R4 cmd rd_reg", {28'd0, cmd}, 3);
    finish_busy();
  endtask

  task automatic t_counts();
    logic [3:0] codes[4] = '{4'd2, 4'd4, 4'd5, 4'd7};
    int         need[4]  = '{0, 3, 2, 0};
    foreach (codes[k]) begin
      send({4'd0, codes[k]});
      for (int i = 0; i < need[k]; i++) begin
        chk("R3 count hold", {31'd0, jump}, 0);
        send(8'h5A);
      end
      chk("R3 count launch", {31'd0, jump}, 1);
      chk("R4 count cmd", {28'd0, cmd}, {28'd0, codes[k]});
      finish_busy();
    end
  endtask

  task automatic t_direct();
    send(8'h08);
    chk("R6 step pulse", {30'd0, step, ret}, 2'b10);
    chk("R6 step status", {30'd0, status}, 2'b01);
    chk("R6 step cmd kept", {28'd0, cmd}, 7);
    @(negedge clk);
    chk("R6 step one cycle", {31'd0, step}, 0);
    send(8'h09);
    chk("R6 ret pulse", {30'd0, step, ret}, 2'b01);
    chk("R6 ret no jump", {31'd0, jump}, 0);
    @(negedge clk);
    chk("R6 ret one cycle", {31'd0, ret}, 0);
  endtask

  task automatic t_dis();
    send(8'h06); send(8'h01); send(8'h02);
    @(negedge clk); txc_set = 1'b1;
    @(negedge clk); txc_set = 1'b0; dis = 1'b1;
    @(negedge clk);
    chk("R9 off status", {30'd0, status}, 2'b00);
    chk("R9 cmd cleared", {28'd0, cmd}, 0);
    chk("R9 txc cleared", {31'd0, txc}, 0);
    chk("R9 rom_en kept", {31'd0, rom_en}, 1);
    rx_byte = 8'h01; rx_done = 1'b1;
    @(negedge clk); rx_done = 1'b0;
    chk("R9 byte ignored", {29'd0, jump, status}, 3'b000);
    dis = 1'b0;
    @(negedge clk);
    chk("R9 idle after release", {30'd0, status}, 2'b01);
    send(8'h03);
    chk("R9 fresh collect", {30'd0, status, jump}, 3'b010);
    send(8'h77);
    chk("R9 fresh launch", {30'd0, status, jump}, 3'b101);
    chk("R9 fresh args", args, 32'h00000077);
    finish_busy();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_nop();
    t_rd_map();
    t_rod_idle();
    t_wr_mem();
    t_rd_reg();
    t_counts();
    t_direct();
    t_dis();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule